// File: doc/BRIEF.md
# External Interrupt Conditioning Module

This block sits between a handful of external interrupt pins and an on-chip interrupt controller. The pins can be level-sensitive or edge-sensitive, and either polarity. The block turns each one into an active-high level request that the controller can consume directly. Every line is first synchronised to the core clock. Its edges are caught in a per-line flag that stays set until software acknowledges it. An enable mask then gates the line onto the registered request vector.

Software drives the block through a small single-cycle register port. Three bit-per-line registers set the trigger kind, the edge direction and the level polarity of each line. Enables are changed through a set port and a clear port, so no read-modify-write is needed. An acknowledge port clears latched edges. Bits for lines that are not built read back as zero. Writing all ones to the trigger register and reading it back therefore gives the number of lines that exist.

Top module: `extint_cond`

## Requirements
- R1: After reset, the trigger, direction, polarity, enable and flag registers all read zero, and `irq_req` is all zero.
- R2: A line whose trigger bit is 1 (level kind) drives its request high while it is enabled and its pin equals its polarity bit (1 means active-high, 0 means active-low). The request falls again once the pin leaves that state. The request follows the pin with a latency of three clock cycles.
- R3: A line whose trigger bit is 0 (edge kind) latches a flag on the edge chosen by its direction bit (1 means rising, 0 means falling). The request stays high while the line is enabled and the flag is set, even after the pin returns to its idle state.
- R4: Writing to offset 3 sets the enable bits that are 1 in the data, and writing to offset 4 clears them. Data bits that are 0 leave the enables unchanged. The enable mask reads back at offset 6, and offset 3 reads as zero.
- R5: A masked line never raises its request. An edge that arrives while the line is masked is still latched, and it is visible at offset 7. It raises the request as soon as the line is enabled.
- R6: Writing a 1 to a bit at offset 5 clears that line's flag. Acknowledging a line before enabling it discards a stale event, so the request stays low after the enable.
- R7: If an acknowledge and a new selected edge reach the same line in the same cycle, the new edge wins and the flag stays set.
- R8: The trigger (offset 0), direction (offset 1) and polarity (offset 2) registers read back their stored values. Read data is registered and appears in the cycle after the read strobe. Bits at or above `N_LINES` always read zero, so writing all ones to offset 0 returns 2^N_LINES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | N_LINES | Asynchronous external interrupt pins |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, single cycle |
| bus_rd | input | 1 | Read strobe, data returned next cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_req | output | N_LINES | Registered active-high requests to the interrupt controller |

## Verification
The acknowledge write and a fresh edge on the same line can hit the flag in the same clock edge. The bench provokes this by changing a pin at a falling clock edge and counting the two synchroniser stages. It then places the acknowledge strobe exactly on the edge where the detector fires. The flag must still read as set afterwards, and the request must stay high. A separate acknowledge with no competing edge must then clear both.

// File: rtl/extint_pkg.sv
package extint_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_TRIG   = 3'd0,
    REG_DIR    = 3'd1,
    REG_POL    = 3'd2,
    REG_EN_SET = 3'd3,
    REG_EN_CLR = 3'd4,
    REG_ACK    = 3'd5,
    REG_MASK   = 3'd6,
    REG_FLAGS  = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/extint_regs.sv
module extint_regs
  import extint_pkg::*;
#(
  parameter int N_LINES = 4,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic               rd_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [N_LINES-1:0] flags_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [N_LINES-1:0] trig_o,
  output logic [N_LINES-1:0] dir_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] en_o,
  output logic [N_LINES-1:0] ack_o
);
  reg_sel_e           sel;
  logic [N_LINES-1:0] wbits;
  logic [N_LINES-1:0] set_bits, clr_bits;
  logic [DATA_W-1:0]  rd_mux;
  logic               unused_wdata;

  assign sel          = reg_sel_e'(addr_i);
  assign wbits        = wdata_i[N_LINES-1:0];
  assign unused_wdata = ^wdata_i;
  assign set_bits     = (wr_i && sel == REG_EN_SET) ? wbits : '0;
  assign clr_bits     = (wr_i && sel == REG_EN_CLR) ? wbits : '0;
  assign ack_o        = (wr_i && sel == REG_ACK)    ? wbits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_o <= '0;
      dir_o  <= '0;
      pol_o  <= '0;
      en_o   <= '0;
    end else begin
      if (wr_i && sel == REG_TRIG) trig_o <= wbits;
      if (wr_i && sel == REG_DIR)  dir_o  <= wbits;
      if (wr_i && sel == REG_POL)  pol_o  <= wbits;
      en_o <= (en_o | set_bits) & ~clr_bits;
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      REG_TRIG:  rd_mux[N_LINES-1:0] = trig_o;
      REG_DIR:   rd_mux[N_LINES-1:0] = dir_o;
      REG_POL:   rd_mux[N_LINES-1:0] = pol_o;
      REG_MASK:  rd_mux[N_LINES-1:0] = en_o;
      REG_FLAGS: rd_mux[N_LINES-1:0] = flags_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else if (rd_i) rdata_o <= rd_mux;
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_ast
    AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
      (wr_i && sel == REG_EN_SET && wdata_i[i]) |=> en_o[i]); // R4
    AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
      (wr_i && sel == REG_EN_CLR && wdata_i[i]) |=> !en_o[i]); // R4
    AST_EN_ZERO_KEEPS: assert property (@(posedge clk) disable iff (rst)
      (wr_i && (sel == REG_EN_SET || sel == REG_EN_CLR) && !wdata_i[i])
        |=> en_o[i] == $past(en_o[i])); // R4
  end
endmodule

// File: rtl/extint_detect.sv
module extint_detect #(
  parameter int N_LINES = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] sync_i,
  input  logic [N_LINES-1:0] trig_i,
  input  logic [N_LINES-1:0] dir_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] en_i,
  input  logic [N_LINES-1:0] ack_i,
  output logic [N_LINES-1:0] flags_o,
  output logic [N_LINES-1:0] irq_o
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] edge_ev;
  logic [N_LINES-1:0] lvl_match;

  assign edge_ev   = (dir_i & sync_i & ~prev_q) | (~dir_i & ~sync_i & prev_q);
  assign lvl_match = ~(sync_i ^ pol_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= '0;
      flags_o <= '0;
      irq_o   <= '0;
    end else begin
      prev_q  <= sync_i;
      flags_o <= (flags_o & ~ack_i) | edge_ev;
      irq_o   <= en_i & ((trig_i & lvl_match) | (~trig_i & flags_o));
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_ast
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (ack_i[i] && !edge_ev[i]) |=> !flags_o[i]); // R6
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
      edge_ev[i] |=> flags_o[i]); // R7
    AST_MASKED_LOW: assert property (@(posedge clk) disable iff (rst)
      !en_i[i] |=> !irq_o[i]); // R5
    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      (en_i[i] && trig_i[i] && lvl_match[i]) |=> irq_o[i]); // R2
    AST_EDGE_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (en_i[i] && !trig_i[i] && flags_o[i]) |=> irq_o[i]); // R3
  end
endmodule

// File: rtl/extint_cond.sv
module extint_cond
  import extint_pkg::*;
#(
  parameter int N_LINES     = 4,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] ext_pin,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [N_LINES-1:0] irq_req
);
  logic [N_LINES-1:0] pin_sync;
  logic [N_LINES-1:0] trig, dir, pol, en, ack, flags;

  extint_sync #(.WIDTH(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_pin),
    .dout (pin_sync)
  );

  extint_regs #(.N_LINES(N_LINES), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .addr_i  (bus_addr),
    .wr_i    (bus_wr),
    .rd_i    (bus_rd),
    .wdata_i (bus_wdata),
    .flags_i (flags),
    .rdata_o (bus_rdata),
    .trig_o  (trig),
    .dir_o   (dir),
    .pol_o   (pol),
    .en_o    (en),
    .ack_o   (ack)
  );

  extint_detect #(.N_LINES(N_LINES)) u_detect (
    .clk     (clk),
    .rst     (rst),
    .sync_i  (pin_sync),
    .trig_i  (trig),
    .dir_i   (dir),
    .pol_i   (pol),
    .en_i    (en),
    .ack_i   (ack),
    .flags_o (flags),
    .irq_o   (irq_req)
  );
endmodule

// File: tb/extint_cond_tb_top.sv
module extint_cond_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NL-1:0] pins = '0;
  logic [2:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NL-1:0] irq_req;

  int checks = 0;
  int errors = 0;

  logic [31:0]   rdv;
  logic [NL-1:0] r_trig, r_dir, r_pol, r_en, r_p0, r_p1, r_flg;

  always #(CLK_PERIOD/2) clk = ~clk;

  extint_cond #(.N_LINES(NL), .DATA_W(32)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .ext_pin   (pins),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_req   (irq_req)
  );

  function automatic logic [NL-1:0] exp_edges(logic [NL-1:0] p0, logic [NL-1:0] p1,
                                              logic [NL-1:0] d);
    return (d & ~p0 & p1) | (~d & p0 & ~p1);
  endfunction

  function automatic logic [NL-1:0] exp_irq(logic [NL-1:0] t, logic [NL-1:0] p,
                                            logic [NL-1:0] e, logic [NL-1:0] pin,
                                            logic [NL-1:0] f);
    return e & ((t & ~(pin ^ p)) | (~t & f));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    d = bus_rdata; bus_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick(5);
    rst = 1'b0;
    tick(1);

    // R1 reset state
    check("R1 irq", {28'd0, irq_req}, 32'd0);
    for (int a = 0; a < 8; a++) begin
      if (a != 3 && a != 4 && a != 5) begin
        rd(a[2:0], rdv);
        check("R1 reg", rdv, 32'd0);
      end
    end

    // R8 readback and implemented-line discovery
    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, rdv); check("R8 trig all ones", rdv, 32'h0000_000F);
    wr(3'd1, 32'hA5A5_A5A6); rd(3'd1, rdv); check("R8 dir", rdv, 32'h0000_0006);
    wr(3'd2, 32'h0000_0009); rd(3'd2, rdv); check("R8 pol", rdv, 32'h0000_0009);
    rd(3'd3, rdv); check("R4 set port reads zero", rdv, 32'd0);
    wr(3'd0, 32'd0); wr(3'd1, 32'd0); wr(3'd2, 32'd0);

    // R4 enable set/clear
    wr(3'd3, 32'h5); rd(3'd6, rdv); check("R4 set", rdv, 32'h5);
    wr(3'd3, 32'h0); rd(3'd6, rdv); check("R4 set zero no effect", rdv, 32'h5);
    wr(3'd4, 32'h0); rd(3'd6, rdv); check("R4 clr zero no effect", rdv, 32'h5);
    wr(3'd4, 32'h1); rd(3'd6, rdv); check("R4 clr", rdv, 32'h4);
    wr(3'd4, 32'hF);

    // R5 edge while masked is latched, request appears on enable
    wr(3'd1, 32'hF);                      // all rising
    wr(3'd5, 32'hF);
    @(negedge clk) pins = 4'b0001;
    tick(6);
    check("R5 masked irq low", {28'd0, irq_req}, 32'd0);
    rd(3'd7, rdv); check("R5 masked edge latched", rdv, 32'h1);
    wr(3'd3, 32'h1); tick(2);
    check("R5 irq after enable", {28'd0, irq_req}, 32'h1);

    // R3 request held after pin returns
    @(negedge clk) pins = 4'b0000;
    tick(6);
    check("R3 edge request held", {28'd0, irq_req}, 32'h1);
    wr(3'd5, 32'h1); tick(2);
    check("R6 ack drops request", {28'd0, irq_req}, 32'h0);

    // R6 stale event discarded by ack before enable
    wr(3'd4, 32'h1);
    @(negedge clk) pins = 4'b0001;
    tick(6);
    wr(3'd5, 32'h1);
    wr(3'd3, 32'h1); tick(3);
    check("R6 stale discarded", {28'd0, irq_req}, 32'h0);
    @(negedge clk) pins = 4'b0000;
    tick(5);

    // R7 ack and new edge on line 1 at the same clock edge
    wr(3'd3, 32'h2);
    wr(3'd5, 32'h2);
    @(negedge clk) pins = 4'b0010;
    @(negedge clk);
    @(negedge clk);
    bus_addr = 3'd5; bus_wdata = 32'h2; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    tick(2);
    rd(3'd7, rdv); check("R7 edge wins flag", rdv & 32'h2, 32'h2);
    check("R7 edge wins irq", {28'd0, irq_req} & 32'h2, 32'h2);
    wr(3'd5, 32'h2); tick(2);
    rd(3'd7, rdv); check("R6 ack alone clears", rdv & 32'h2, 32'h0);
    @(negedge clk) pins = 4'b0000;
    tick(5);
    wr(3'd4, 32'hF);

    // R2 level, active-low line 2
    wr(3'd0, 32'h4); wr(3'd2, 32'h0);
    wr(3'd3, 32'h4); tick(2);
    check("R2 active-low asserted", {28'd0, irq_req}, 32'h4);
    @(negedge clk) pins = 4'b0100;
    tick(3);
    check("R2 level drops", {28'd0, irq_req}, 32'h0);
    wr(3'd4, 32'hF);

    // Random configurations and pin transitions (R2 R3 R5)
    for (int it = 0; it < 60; it++) begin
      r_trig = 4'($urandom); r_dir = 4'($urandom); r_pol = 4'($urandom);
      r_en = 4'($urandom); r_p0 = 4'($urandom); r_p1 = 4'($urandom);
      wr(3'd4, 32'hF);
      wr(3'd0, {28'd0, r_trig}); wr(3'd1, {28'd0, r_dir}); wr(3'd2, {28'd0, r_pol});
      @(negedge clk) pins = r_p0;
      tick(6);
      wr(3'd5, 32'hF);
      wr(3'd3, {28'd0, r_en});
      @(negedge clk) pins = r_p1;
      tick(6);
      r_flg = exp_edges(r_p0, r_p1, r_dir);
      check("R2/R3/R5 random irq", {28'd0, irq_req},
            {28'd0, exp_irq(r_trig, r_pol, r_en, r_p1, r_flg)});
      rd(3'd7, rdv); check("R3 random flags", rdv, {28'd0, r_flg});
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule